// File: doc/BRIEF.md
# Integer Multiply-Accumulate Unit with Accumulator

This unit carries out integer multiplies on the low 32-bit halves of two 64-bit operands, and it owns a private 64-bit accumulator that software can see. An operation is selected by a group code, a sub-code and a signed-select bit. The unit offers four operations:

- a plain multiply;
- a multiply that also loads the accumulator;
- a multiply that adds into the accumulator;
- a move that copies operand A into both the result and the accumulator.

Each accepted request produces exactly one result cycle on the following clock. That cycle carries a destination-write strobe. The strobe is withheld when the unit is disabled or the code is not recognised.

The response side is a four-state machine: `ST_IDLE`, `ST_WRITE`, `ST_UNAVAIL` and `ST_ILLEGAL`. Every clock, the machine moves to one of these states, chosen by the request it samples:

- no request goes to `ST_IDLE`;
- a request with `unit_en` low goes to `ST_UNAVAIL`;
- an unknown code with `unit_en` high goes to `ST_ILLEGAL`;
- anything else goes to `ST_WRITE`.

The machine can go from any state to any state. The accumulator is updated on the same edge that enters `ST_WRITE`. This lets a request issued in the very next cycle read the new value.

Top module: `mac_acc_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `res_valid` is 0 and `acc_value` is 0.
- R2: Plain multiply (group 0x11, sub 0x0C) writes the 64-bit product to `res_data` with `res_wr`=1 and leaves `acc_value` unchanged.
- R3: Multiply-and-load (group 0x11, sub 0x1C) writes the product to `res_data` and also sets `acc_value` to that product.
- R4: Multiply-and-accumulate (group 0x15, sub 0x0C) sets `acc_value` to the old accumulator plus the product, modulo 2^64. `res_data` carries this new sum.
- R5: Move (group 0x13, sub 0x02, `req_signed`=0) copies all 64 bits of `src_a` to both `res_data` and `acc_value`.
- R6: A request with `unit_en`=0 gives `res_valid`=1, `exc_unavail`=1, `res_wr`=0 and `exc_illegal`=0, and leaves `acc_value` unchanged. This applies even when the code is also unknown.
- R7: A request with `unit_en`=1 and any other code, including the move with `req_signed`=1, gives `exc_illegal`=1 and `res_wr`=0, and leaves `acc_value` unchanged.
- R8: Back-to-back accumulate or move requests with no idle cycle each see the accumulator value written by the request before.
- R9: Every request cycle is followed by exactly one cycle with `res_valid`=1. A cycle with no request is followed by `res_valid`=0. At most one of `res_wr`, `exc_unavail` and `exc_illegal` is set.
- R10: Only bits 31:0 of `src_a` and `src_b` take part in a multiply. With `req_signed`=0 they are zero-extended; with `req_signed`=1 they are sign-extended. The full 64-bit product is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| unit_en | input | 1 | Unit enable; low turns every request into an exception |
| req_valid | input | 1 | Request present this cycle |
| req_group | input | 6 | Operation group code |
| req_sub | input | 5 | Operation sub-code within the group |
| req_signed | input | 1 | 1 selects the signed form |
| src_a | input | 64 | Operand A |
| src_b | input | 64 | Operand B |
| res_valid | output | 1 | Result cycle for the previous request |
| res_wr | output | 1 | Destination write strobe |
| res_data | output | 64 | Destination value, meaningful when res_wr is 1 |
| exc_unavail | output | 1 | Unit-disabled exception |
| exc_illegal | output | 1 | Unknown-code exception |
| acc_value | output | 64 | Current accumulator contents |

## Verification
The two functions that can fall in the same cycle are the accumulator update by one request and the accumulator read by the next request. A fault can also land between two accumulating requests. The bench provokes this with unbroken chains of accumulate, load and move requests, including a chain where the sum wraps past 2^64. Disabled and unknown-code requests are dropped into the middle of such chains. A behavioural model keeps its own accumulator and judges `res_data` and `acc_value` on every clock; a stale or doubly-applied accumulator shows up as a mismatch there.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int GRP_W = 6;
    localparam int SUB_W = 5;

    localparam logic [GRP_W-1:0] GRP_MULW = 6'h11;
    localparam logic [GRP_W-1:0] GRP_MOVE = 6'h13;
    localparam logic [GRP_W-1:0] GRP_ACCW = 6'h15;
    localparam logic [SUB_W-1:0] SUB_MUL  = 5'h0C;
    localparam logic [SUB_W-1:0] SUB_LOAD = 5'h1C;
    localparam logic [SUB_W-1:0] SUB_MOVE = 5'h02;

    typedef enum logic [2:0] {
        OP_MUL,
        OP_MULLD,
        OP_MAC,
        OP_MOVE,
        OP_BAD
    } op_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_UNAVAIL,
        ST_ILLEGAL
    } rsp_state_t;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
    import mac_pkg::*;
(
    input  logic [GRP_W-1:0] grp,
    input  logic [SUB_W-1:0] sub,
    input  logic             sgn,
    output op_kind_t         kind
);
    always_comb begin
        kind = OP_BAD;
        if (grp == GRP_MULW && sub == SUB_MUL) begin
            kind = OP_MUL;
        end else if (grp == GRP_MULW && sub == SUB_LOAD) begin
            kind = OP_MULLD;
        end else if (grp == GRP_ACCW && sub == SUB_MUL) begin
            kind = OP_MAC;
        end else if (grp == GRP_MOVE && sub == SUB_MOVE && !sgn) begin
            kind = OP_MOVE;
        end
    end
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int DATA_W = 64,
    parameter int SRC_W  = 32
) (
    input  logic [SRC_W-1:0]  a_lo,
    input  logic [SRC_W-1:0]  b_lo,
    input  logic              sgn,
    output logic [DATA_W-1:0] prod
);
    localparam int PAD_W = DATA_W - SRC_W;

    logic [DATA_W-1:0] a_ext;
    logic [DATA_W-1:0] b_ext;

    generate
        if (PAD_W > 0) begin : g_pad
            assign a_ext = {{PAD_W{sgn & a_lo[SRC_W-1]}}, a_lo};
            assign b_ext = {{PAD_W{sgn & b_lo[SRC_W-1]}}, b_lo};
        end else begin : g_nopad
            assign a_ext = a_lo;
            assign b_ext = b_lo;
        end
    endgenerate

    assign prod = a_ext * b_ext;
endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
    import mac_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SRC_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 unit_en,
    input  logic                 req_valid,
    input  logic [GRP_W-1:0]     req_group,
    input  logic [SUB_W-1:0]     req_sub,
    input  logic                 req_signed,
    input  logic [DATA_W-1:0]    src_a,
    input  logic [DATA_W-1:0]    src_b,
    output logic                 res_valid,
    output logic                 res_wr,
    output logic [DATA_W-1:0]    res_data,
    output logic                 exc_unavail,
    output logic                 exc_illegal,
    output logic [DATA_W-1:0]    acc_value
);
    op_kind_t          kind;
    op_kind_t          kind_q;
    rsp_state_t        state_q;
    rsp_state_t        state_d;
    logic [DATA_W-1:0] prod;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] acc_d;
    logic [DATA_W-1:0] result_d;
    logic [DATA_W-1:0] result_q;
    logic              acc_we;
    logic              commit;
    logic              hi_unused;

    assign hi_unused = ^src_b[DATA_W-1:SRC_W];

    mac_decode u_dec (
        .grp  (req_group),
        .sub  (req_sub),
        .sgn  (req_signed),
        .kind (kind)
    );

    mac_mult #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_mul (
        .a_lo (src_a[SRC_W-1:0]),
        .b_lo (src_b[SRC_W-1:0]),
        .sgn  (req_signed),
        .prod (prod)
    );

    mac_acc_reg #(.DATA_W(DATA_W)) u_acc (
        .clk (clk),
        .rst (rst),
        .we  (acc_we),
        .d   (acc_d),
        .q   (acc_value)
    );

    // next response state
    always_comb begin
        if (!req_valid) begin
            state_d = ST_IDLE;
        end else if (!unit_en) begin
            state_d = ST_UNAVAIL;
        end else if (kind == OP_BAD) begin
            state_d = ST_ILLEGAL;
        end else begin
            state_d = ST_WRITE;
        end
    end

    assign commit = (state_d == ST_WRITE);
    assign sum    = acc_value + prod;

    // datapath selection for the committing request
    always_comb begin
        result_d = prod;
        acc_d    = prod;
        acc_we   = 1'b0;
        unique case (kind)
            OP_MUL: begin
                result_d = prod;
            end
            OP_MULLD: begin
                acc_we = commit;
            end
            OP_MAC: begin
                result_d = sum;
                acc_d    = sum;
                acc_we   = commit;
            end
            OP_MOVE: begin
                result_d = src_a;
                acc_d    = src_a;
                acc_we   = commit;
            end
            default: begin
                acc_we = 1'b0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // result and kind capture
    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            kind_q   <= OP_BAD;
        end else if (commit) begin
            result_q <= result_d;
            kind_q   <= kind;
        end
    end

    // outputs from state
    always_comb begin
        res_valid   = 1'b0;
        res_wr      = 1'b0;
        exc_unavail = 1'b0;
        exc_illegal = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                res_valid = 1'b0;
            end
            ST_WRITE: begin
                res_valid = 1'b1;
                res_wr    = 1'b1;
            end
            ST_UNAVAIL: begin
                res_valid   = 1'b1;
                exc_unavail = 1'b1;
            end
            ST_ILLEGAL: begin
                res_valid   = 1'b1;
                exc_illegal = 1'b1;
            end
            default: begin
                res_valid = 1'b0;
            end
        endcase
    end

    assign res_data = result_q;

    p_lat_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    p_noreq_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);
    p_flags_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({res_wr, exc_unavail, exc_illegal}));
    p_dis_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !unit_en) |=> (exc_unavail && !res_wr && $stable(acc_value)));
    p_bad_r7: assert property (@(posedge clk) disable iff (rst)
        exc_illegal |-> $stable(acc_value));
    p_accres_r4: assert property (@(posedge clk) disable iff (rst)
        (res_wr && kind_q inside {OP_MULLD, OP_MAC, OP_MOVE}) |-> (res_data == acc_value));
    p_plain_r2: assert property (@(posedge clk) disable iff (rst)
        (res_wr && kind_q == OP_MUL) |-> $stable(acc_value));
endmodule

// File: tb/mac_acc_unit_test.sv
module mac_acc_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        unit_en;
    logic        req_valid;
    logic [5:0]  req_group;
    logic [4:0]  req_sub;
    logic        req_signed;
    logic [63:0] src_a;
    logic [63:0] src_b;
    logic        res_valid;
    logic        res_wr;
    logic [63:0] res_data;
    logic        exc_unavail;
    logic        exc_illegal;
    logic [63:0] acc_value;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [63:0] acc_m = 64'd0;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;
    bit          done = 0;

    always #2.5 clk = ~clk;

    mac_acc_unit uut (
        .clk(clk), .rst(rst), .unit_en(unit_en), .req_valid(req_valid),
        .req_group(req_group), .req_sub(req_sub), .req_signed(req_signed),
        .src_a(src_a), .src_b(src_b), .res_valid(res_valid), .res_wr(res_wr),
        .res_data(res_data), .exc_unavail(exc_unavail), .exc_illegal(exc_illegal),
        .acc_value(acc_value)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_prod(logic [63:0] a, logic [63:0] b, bit s);
        longint          sa;
        longint          sb;
        longint unsigned ua;
        longint unsigned ub;
        if (s) begin
            sa = $signed(a[31:0]);
            sb = $signed(b[31:0]);
            return sa * sb;
        end
        ua = a[31:0];
        ub = b[31:0];
        return ua * ub;
    endfunction

    function automatic logic [63:0] nxt();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    // called at a falling edge; drives one cycle and checks the response one cycle later
    task automatic step(bit v, bit en, logic [5:0] g, logic [4:0] s, bit sg,
                        logic [63:0] a, logic [63:0] b, string tag);
        bit          e_valid;
        bit          e_wr;
        bit          e_un;
        bit          e_il;
        logic [63:0] e_data;
        int          k;
        req_valid  = v;
        unit_en    = en;
        req_group  = g;
        req_sub    = s;
        req_signed = sg;
        src_a      = a;
        src_b      = b;
        k = 4;
        if (g == 6'h11 && s == 5'h0C) k = 0;
        else if (g == 6'h11 && s == 5'h1C) k = 1;
        else if (g == 6'h15 && s == 5'h0C) k = 2;
        else if (g == 6'h13 && s == 5'h02 && !sg) k = 3;
        e_valid = v;
        e_un    = v && !en;
        e_il    = v && en && (k == 4);
        e_wr    = v && en && (k != 4);
        e_data  = 64'd0;
        if (e_wr) begin
            case (k)
                0: e_data = ref_prod(a, b, sg);
                1: begin e_data = ref_prod(a, b, sg); acc_m = e_data; end
                2: begin e_data = acc_m + ref_prod(a, b, sg); acc_m = e_data; end
                default: begin e_data = a; acc_m = a; end
            endcase
        end
        @(negedge clk);
        chk(tag, "res_valid", {63'd0, res_valid}, {63'd0, e_valid});
        chk(tag, "res_wr", {63'd0, res_wr}, {63'd0, e_wr});
        chk(tag, "exc_unavail", {63'd0, exc_unavail}, {63'd0, e_un});
        chk(tag, "exc_illegal", {63'd0, exc_illegal}, {63'd0, e_il});
        if (e_wr) chk(tag, "res_data", res_data, e_data);
        chk(tag, "acc_value", acc_value, acc_m);
    endtask

    initial begin
        rst = 1'b1; unit_en = 1'b1; req_valid = 1'b0; req_group = '0; req_sub = '0;
        req_signed = 1'b0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        chk("R1", "res_valid in reset", {63'd0, res_valid}, 64'd0);
        chk("R1", "acc in reset", acc_value, 64'd0);
        rst = 1'b0;
        step(0, 1, 6'h00, 5'h00, 0, 64'd0, 64'd0, "R1");
        step(0, 1, 6'h11, 5'h0C, 0, 64'd7, 64'd7, "R9");
        // multiply forms with garbage in the upper halves
        step(1, 1, 6'h11, 5'h0C, 0, 64'hDEAD_BEEF_0000_0003, 64'h1234_5678_0000_0005, "R2");
        step(1, 1, 6'h11, 5'h0C, 1, 64'h0000_0001_FFFF_FFFD, 64'd7, "R10");
        step(1, 1, 6'h11, 5'h0C, 0, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R10");
        step(1, 1, 6'h11, 5'h0C, 1, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R10");
        step(1, 1, 6'h11, 5'h1C, 1, 64'h8000_0000, 64'h7FFF_FFFF, "R3");
        step(1, 1, 6'h11, 5'h1C, 0, 64'h10, 64'h20, "R3");
        // accumulate chain with no gaps
        step(1, 1, 6'h15, 5'h0C, 0, 64'd3, 64'd4, "R4");
        step(1, 1, 6'h15, 5'h0C, 1, 64'hFFFF_FFFF, 64'd100, "R8");
        step(1, 1, 6'h15, 5'h0C, 0, 64'd9, 64'd9, "R8");
        // move then wrap
        step(1, 1, 6'h13, 5'h02, 0, 64'hFFFF_FFFF_FFFF_FFF0, 64'd1, "R5");
        step(1, 1, 6'h15, 5'h0C, 0, 64'd4, 64'd5, "R4");
        step(1, 1, 6'h15, 5'h0C, 0, 64'd2, 64'd3, "R8");
        // faults inside a chain
        step(1, 0, 6'h15, 5'h0C, 0, 64'd50, 64'd50, "R6");
        step(1, 0, 6'h13, 5'h02, 0, 64'h55, 64'd0, "R6");
        step(1, 0, 6'h3F, 5'h1F, 1, 64'd1, 64'd1, "R6");
        step(1, 1, 6'h13, 5'h02, 1, 64'h77, 64'd0, "R7");
        step(1, 1, 6'h11, 5'h05, 0, 64'd2, 64'd2, "R7");
        step(1, 1, 6'h15, 5'h1C, 0, 64'd2, 64'd2, "R7");
        step(1, 1, 6'h15, 5'h0C, 1, 64'hFFFF_FFFE, 64'd3, "R8");
        step(0, 1, 6'h15, 5'h0C, 0, 64'd1, 64'd1, "R9");
        // mixed stream
        for (int i = 0; i < 400; i++) begin
            logic [63:0] r;
            logic [63:0] ra;
            logic [63:0] rb;
            logic [5:0]  g;
            logic [4:0]  s;
            r  = nxt();
            ra = nxt();
            rb = nxt();
            case (r[2:0])
                3'd0: begin g = 6'h11; s = 5'h0C; end
                3'd1: begin g = 6'h11; s = 5'h1C; end
                3'd2, 3'd3: begin g = 6'h15; s = 5'h0C; end
                3'd4: begin g = 6'h13; s = 5'h02; end
                3'd5: begin g = r[13:8]; s = r[20:16]; end
                default: begin g = 6'h15; s = 5'h0C; end
            endcase
            step(r[30:28] != 3'd0, r[35:33] != 3'd0, g, s, r[40], ra, rb, "R8");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(100_000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule